// File: doc/BRIEF.md
# Masked interrupt status controller

This block gathers the interrupt conditions of a network interface into one status byte, holds an enable byte beside it, and drives a single hardware interrupt line. The line is high whenever any status flag is set and its enable bit is also set.

Status flags come in two kinds:

- **Sticky flags** are set by single-cycle event pulses from the transmit, receive-overrun and management-interrupt logic. They stay set until the host clears them.
- **Level flags** copy, one cycle late, the current level of the receive-ready, allocation-done and protocol-exception summary inputs. The host does not clear these.

The host reaches the block through one 16-bit register word:

- **Low byte.** A read returns the status byte. A write acts as an acknowledge byte, where a 1 clears the matching sticky flag.
- **High byte.** This is the read/write enable mask.

Each byte lane has its own enable, so the host can access the two bytes separately or as one word.

The interrupt line comes from a two-state machine. The states are IRQ_QUIET (the line is low) and IRQ_RAISED (the line is high). Each clock edge the machine takes one of four transitions:

- QUIET→RAISED when a masked flag is pending.
- RAISED→QUIET when nothing is pending.
- QUIET→QUIET when nothing is pending.
- RAISED→RAISED when a masked flag is still pending.

Because of this, the line follows the masked status one cycle late, and the bus write data has no combinational path to it.

Top module: `isc_irq_ctrl`

## Requirements
- R1: After reset the mask byte, the status byte and irq_o are all 0.
- R2: Mask bit 6 is reserved. It always reads 0, and writes to it are ignored. The other mask bits (7 management, 5 exception, 4 receive overrun, 3 allocation, 2 transmit empty, 1 transmit done, 0 receive) store what is written.
- R3: A one-cycle pulse on evt_mgmt, evt_rx_ovrn, evt_tx_empty or evt_tx_done sets status bit 7, 4, 2 or 1 respectively at the next clock edge. The bit then stays set until it is acknowledged.
- R4: A write with bus_be[0]=1 clears each sticky status bit (7, 4, 2, 1) whose data bit in bus_wdata[7:0] is 1. A data bit of 0, and any bit in a level or reserved position, has no effect.
- R5: If an event pulse and an acknowledge of the same bit arrive in one cycle, the status bit stays set.
- R6: Status bits 5, 3 and 0 show the levels of lvl_exc, lvl_alloc and lvl_rcv as they were at the previous clock edge. Status bit 6 always reads 0.
- R7: irq_o is 1 exactly when, one cycle earlier, some status bit and its mask bit were both 1.
- R8: Only bus_be[1] writes the mask (from bus_wdata[15:8]), and only bus_be[0] acknowledges. A write with both bits set does both in the same cycle. Without bus_be[1] the mask holds its value.
- R9: bus_rdata returns {mask, status} at all times. Reading the acknowledge lane therefore returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register word |
| bus_be | input | 2 | Byte-lane enables: bit 0 is status/acknowledge, bit 1 is mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data {mask, status} |
| evt_mgmt | input | 1 | Management-interface change pulse |
| evt_rx_ovrn | input | 1 | Receive overrun pulse |
| evt_tx_empty | input | 1 | Transmit queue empty pulse |
| evt_tx_done | input | 1 | Transmit complete pulse |
| lvl_rcv | input | 1 | Receive-ready level |
| lvl_alloc | input | 1 | Allocation-done level |
| lvl_exc | input | 1 | Merged protocol-exception summary level |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that the event inputs and the write strobe are sampled only at rising edges, and that they are valid, non-X levels from the first edge after reset onward. The level-copy and event-wins checks rely on this, because they compare a flag with a $past input. The bench drives every input on falling edges, starting from defined zeros at time zero. During the random phase it changes inputs only on those falling edges. Pulses and acknowledges deliberately overlap, which exercises the event-wins case that the assertions state.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int unsigned REG_W = 8;
    localparam logic [REG_W-1:0] STICKY_BITS = 8'h96;
    localparam logic [REG_W-1:0] LEVEL_BITS  = 8'h29;
    localparam logic [REG_W-1:0] RSVD_BITS   = 8'h40;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] RSVD = 8'h40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RSVD[i]) begin : g_rsvd
            assign mask[i] = 1'b0;
        end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  mask[i] <= 1'b0;
                else if (we) mask[i] <= wdata[i];
            end
        end
    end

    wire unused_bits = &{1'b0, wdata & RSVD};

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask)); // R8
endmodule

// File: rtl/isc_status_flags.sv
module isc_status_flags #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] STICKY = 8'h96,
    parameter logic [W-1:0] LEVEL  = 8'h29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    localparam logic [W-1:0] USED = STICKY | LEVEL;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      flags[i] <= 1'b0;
                else if (src[i]) flags[i] <= 1'b1;
                else if (clr[i]) flags[i] <= 1'b0;
            end

            AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                src[i] |=> flags[i]); // R5
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !src[i]) |=> !flags[i]); // R4
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[i] && !src[i]) |=> $stable(flags[i])); // R3
        end else if (LEVEL[i]) begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= src[i];
            end

            AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (flags[i] == $past(src[i]))); // R6
        end else begin : g_zero
            assign flags[i] = 1'b0;
        end
    end

    wire unused_bits = &{1'b0, src & ~USED, clr & ~STICKY};
endmodule

// File: rtl/isc_irq_fsm.sv
module isc_irq_fsm
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq); // R7
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq); // R7
endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
    import isc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        evt_mgmt,
    input  logic        evt_rx_ovrn,
    input  logic        evt_tx_empty,
    input  logic        evt_tx_done,
    input  logic        lvl_rcv,
    input  logic        lvl_alloc,
    input  logic        lvl_exc,
    output logic        irq_o
);
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] src_vec;
    logic [REG_W-1:0] ack_vec;
    logic             mask_we;
    logic             pending;

    assign src_vec = {evt_mgmt, 1'b0, lvl_exc, evt_rx_ovrn,
                      lvl_alloc, evt_tx_empty, evt_tx_done, lvl_rcv};
    assign mask_we = bus_wr & bus_be[1];
    assign ack_vec = (bus_wr & bus_be[0]) ? bus_wdata[REG_W-1:0] : '0;
    assign pending = |(status_q & mask_q);

    isc_mask_reg #(.W(REG_W), .RSVD(RSVD_BITS)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (bus_wdata[2*REG_W-1:REG_W]),
        .mask  (mask_q)
    );

    isc_status_flags #(.W(REG_W), .STICKY(STICKY_BITS), .LEVEL(LEVEL_BITS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_vec),
        .clr   (ack_vec),
        .flags (status_q)
    );

    isc_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq_o)
    );

    assign bus_rdata = {mask_q, status_q};

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !evt_mgmt && !evt_rx_ovrn && !evt_tx_empty && !evt_tx_done
         && !lvl_rcv && !lvl_alloc && !lvl_exc && bus_rdata[5] == 1'b0
         && bus_rdata[3] == 1'b0 && bus_rdata[0] == 1'b0)
        |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/isc_irq_ctrl_tb.sv
module isc_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_wr = 1'b0;
    logic [1:0]  s_be = 2'b00;
    logic [15:0] s_wd = 16'h0000;
    logic [3:0]  s_ev = 4'b0000;
    logic [2:0]  s_lv = 3'b000;
    logic [15:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    isc_irq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (s_wr),
        .bus_be       (s_be),
        .bus_wdata    (s_wd),
        .bus_rdata    (rdata),
        .evt_mgmt     (s_ev[3]),
        .evt_rx_ovrn  (s_ev[2]),
        .evt_tx_empty (s_ev[1]),
        .evt_tx_done  (s_ev[0]),
        .lvl_rcv      (s_lv[0]),
        .lvl_alloc    (s_lv[1]),
        .lvl_exc      (s_lv[2])
        ,.irq_o       (irq)
    );

    // behavioural reference model
    logic [7:0] m_mask = 8'h00;
    logic [7:0] m_stat = 8'h00;
    logic       m_irq  = 1'b0;

    always @(posedge clk) begin
        logic [7:0] ev_pos;
        logic [7:0] nstat;
        if (!rst_n) begin
            m_mask = 8'h00; m_stat = 8'h00; m_irq = 1'b0;
        end else begin
            ev_pos = {s_ev[3], 2'b00, s_ev[2], 1'b0, s_ev[1], s_ev[0], 1'b0};
            nstat  = m_stat;
            for (int b = 0; b < 8; b++) begin
                if (b == 7 || b == 4 || b == 2 || b == 1) begin
                    if (ev_pos[b]) nstat[b] = 1'b1;
                    else if (s_wr && s_be[0] && s_wd[b]) nstat[b] = 1'b0;
                end
            end
            nstat[0] = s_lv[0];
            nstat[3] = s_lv[1];
            nstat[5] = s_lv[2];
            nstat[6] = 1'b0;
            m_irq  = (m_stat & m_mask) != 8'h00;
            if (s_wr && s_be[1]) m_mask = s_wd[15:8] & 8'hBF;
            m_stat = nstat;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rdata[15:8] == m_mask, "R2/R8 mask", {8'h00, rdata[15:8]}, {8'h00, m_mask});
            check(rdata[7:0] == m_stat, "R3/R4/R5/R6 status", {8'h00, rdata[7:0]}, {8'h00, m_stat});
            check(irq == m_irq, "R7 irq", {15'h0, irq}, {15'h0, m_irq});
        end
    end

    task automatic drive(input logic wr, input logic [1:0] be, input logic [15:0] wd,
                         input logic [3:0] ev, input logic [2:0] lv);
        @(negedge clk);
        s_wr = wr; s_be = be; s_wd = wd; s_ev = ev; s_lv = lv;
    endtask

    task automatic idle();
        drive(1'b0, 2'b00, 16'h0000, 4'b0000, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(rdata == 16'h0000, "R1 rdata after reset", rdata, 16'h0000);
        check(irq == 1'b0, "R1 irq after reset", {15'h0, irq}, 16'h0000);

        // R2: reserved mask bit ignores writes
        drive(1'b1, 2'b11, 16'hFF00, 4'b0000, 3'b000); idle();
        check(rdata[15:8] == 8'hBF, "R2 reserved mask bit", {8'h00, rdata[15:8]}, 16'h00BF);

        // R3: transmit-done pulse sets bit 1
        drive(1'b0, 2'b00, 16'h0000, 4'b0001, 3'b000); idle();
        check(rdata[7:0] == 8'h02, "R3 sticky set", {8'h00, rdata[7:0]}, 16'h0002);
        check(irq == 1'b0, "R7 irq lags status", {15'h0, irq}, 16'h0000);
        idle();
        check(irq == 1'b1, "R7 irq raised", {15'h0, irq}, 16'h0001);
        check(rdata[7:0] == 8'h02, "R3 sticky holds", {8'h00, rdata[7:0]}, 16'h0002);

        // R4: acknowledge with zero has no effect
        drive(1'b1, 2'b01, 16'h0000, 4'b0000, 3'b000); idle();
        check(rdata[7:0] == 8'h02, "R4 zero ack ignored", {8'h00, rdata[7:0]}, 16'h0002);

        // R8: high lane only writes mask, no acknowledge
        drive(1'b1, 2'b10, 16'h0002, 4'b0000, 3'b000); idle();
        check(rdata == 16'h0002, "R8 high lane only", rdata, 16'h0002);
        idle();
        check(irq == 1'b0, "R7 mask blocks irq", {15'h0, irq}, 16'h0000);

        // R4: acknowledge clears
        drive(1'b1, 2'b01, 16'h0002, 4'b0000, 3'b000); idle();
        check(rdata[7:0] == 8'h00, "R4 ack clears", {8'h00, rdata[7:0]}, 16'h0000);

        // R5: event wins over acknowledge in the same cycle
        drive(1'b1, 2'b01, 16'h0080, 4'b1000, 3'b000); idle();
        check(rdata[7:0] == 8'h80, "R5 event beats ack", {8'h00, rdata[7:0]}, 16'h0080);
        drive(1'b1, 2'b11, 16'h0180, 4'b0000, 3'b000); idle();
        check(rdata == 16'h0100, "R8 word write acks and masks", rdata, 16'h0100);

        // R6 and R4: level bits track inputs, ack does not touch them
        drive(1'b1, 2'b01, 16'h00FF, 4'b0000, 3'b111); idle();
        check(rdata[7:0] == 8'h29, "R6 level bits / R4 ack ignored", {8'h00, rdata[7:0]}, 16'h0029);
        check(rdata[6] == 1'b0, "R6 reserved status bit", {15'h0, rdata[6]}, 16'h0000);
        idle();
        check(rdata[7:0] == 8'h00, "R6 level bits drop", {8'h00, rdata[7:0]}, 16'h0000);
        check(irq == 1'b1, "R7 level source raises irq", {15'h0, irq}, 16'h0001);
        idle();
        check(irq == 1'b0, "R7 irq drops", {15'h0, irq}, 16'h0000);

        // R9 and all: random traffic compared against the model every cycle
        for (int k = 0; k < 400; k++) begin
            drive(1'($urandom_range(0, 2) == 0), 2'($urandom), 16'($urandom),
                  4'($urandom) & 4'($urandom), 3'($urandom));
            check(rdata == {m_mask, m_stat}, "R9 read word", rdata, {m_mask, m_stat});
        end
        idle(); idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule